// File: doc/BRIEF.md
# Framed Byte Stream Checksum Verifier

The block watches a stream of bytes that arrive one at a time on a valid/ready handshake. The stream is a series of frames. Each frame opens with a count byte that says how many bytes come after it. The last of those bytes is an 8-bit check value. Every byte between the count and the check value is a payload byte. The block adds the payload bytes together, keeping only the low 8 bits of the total. When the check value arrives, it compares the two.

It then raises a one-cycle done pulse. In the same cycle it presents a verdict byte. The verdict is 00h when the check value equals the sum and FFh when it does not. A count byte of zero is a malformed frame and is refused at once with FFh.

The verdict stays on the output until the next verdict replaces it. The byte that follows a check value, or a zero count, always opens a new frame. The block never stalls the sender once it is out of reset.

Top module: `frame_sum_check`

## Requirements
- R1: While reset is asserted, done is 0, result is 00h and in_ready is 0. The reset input is released through a two-stage synchroniser, so in_ready becomes 1 within three clock edges after the release.
- R2: A byte is taken only on a rising edge where in_valid and in_ready are both 1. The first byte taken in a frame is a count N (1 to 255) of the bytes that follow it. The Nth byte after the count is the check value, and the N-1 bytes before it are payload.
- R3: The payload sum is the modulo-256 total of the payload bytes only; the count byte is not included. A check value equal to that sum gives result 00h.
- R4: A check value different from the payload sum gives result FFh.
- R5: A count byte of 00h ends the frame on the edge that takes it. done is then 1 in the following cycle with result FFh, and the next byte taken is again a count.
- R6: done is 1 for exactly the one cycle that follows the edge taking a check value or a zero count, and is 0 in every other cycle.
- R7: result changes only in a cycle in which done is 1 and holds its value in every other cycle.
- R8: While in_valid is 0, in_byte is ignored: it is not counted and not added to the sum.
- R9: Frames may follow one another with no idle cycle. The byte taken on the edge after a check value is treated as the next count.
- R10: A count of 1 means a frame with no payload, whose sum is 00h. Such a frame passes only when its check value is 00h.
- R11: Once in_ready has become 1 after reset, it stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_byte | input | 8 | Incoming stream byte |
| in_valid | input | 1 | in_byte holds a byte to transfer |
| in_ready | output | 1 | Block can take a byte |
| done | output | 1 | One-cycle pulse marking a verdict |
| result | output | 8 | Verdict: 00h pass, FFh fail |

## Verification
The bound properties check the following on every cycle:
- that the pulse and the verdict only ever follow a taken byte;
- that the verdict byte holds between pulses and only ever takes one of its two codes;
- that ready never drops;
- that a zero count is refused in the next cycle;
- that a verdict always leaves the sequencer waiting for a count.

Some behaviour only the bench scenarios can show:
- whether the arithmetic is right: the wrap-around of the sum, a count byte left out of the total, and the empty payload;
- that idle cycles with garbage on the data input leave the frame untouched;
- that the frame boundaries fall where the count byte says, both back to back and with gaps.

// File: rtl/frame_sum_check_pkg.sv
package frame_sum_check_pkg;
  typedef enum logic {
    ST_COUNT = 1'b0,
    ST_BODY  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/frame_seq.sv
module frame_seq
  import frame_sum_check_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] byte_in,
  output logic         at_count,
  output logic         start_frame,
  output logic         zero_count,
  output logic         add_payload,
  output logic         last_byte
);
  localparam logic [W-1:0] ONE = W'(1);

  seq_state_t   st_q, st_d;
  logic [W-1:0] left_q, left_d;

  // decode of the current byte's role
  always_comb begin
    at_count    = (st_q == ST_COUNT);
    start_frame = take && at_count;
    zero_count  = start_frame && (byte_in == '0);
    last_byte   = take && !at_count && (left_q == ONE);
    add_payload = take && !at_count && (left_q != ONE);
  end

  // next-state
  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    if (start_frame && !zero_count) begin
      st_d   = ST_BODY;
      left_d = byte_in;
    end else if (last_byte) begin
      st_d   = ST_COUNT;
      left_d = '0;
    end else if (add_payload) begin
      left_d = left_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_COUNT;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/sum_acc.sv
module sum_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add_en,
  input  logic [W-1:0] byte_in,
  output logic [W-1:0] sum
);
  logic [W-1:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (clr)         sum_d = '0;
    else if (add_en) sum_d = sum_q + byte_in;  // wraps modulo 2**W
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum = sum_q;
endmodule

// File: rtl/verdict_reg.sv
module verdict_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         finish,
  input  logic         reject,
  input  logic [W-1:0] sum,
  input  logic [W-1:0] check_byte,
  output logic         done,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] PASS = '0;
  localparam logic [W-1:0] FAIL_CODE = '1;

  logic         done_q, done_d;
  logic [W-1:0] res_q, res_d;

  always_comb begin
    done_d = finish || reject;
    res_d  = res_q;
    if (reject)      res_d = FAIL_CODE;
    else if (finish) res_d = (sum == check_byte) ? PASS : FAIL_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res_q  <= PASS;
    end else begin
      done_q <= done_d;
      res_q  <= res_d;
    end
  end

  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/frame_sum_check.sv
module frame_sum_check #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_byte,
  input  logic         in_valid,
  output logic         in_ready,
  output logic         done,
  output logic [W-1:0] result
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       rdy_q;
  logic       take;
  logic       at_count, start_frame, zero_count, add_payload, last_byte;
  logic [W-1:0] sum;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdy_q <= 1'b0;
    else            rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign take     = in_valid && rdy_q;

  frame_seq #(.W(W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .take        (take),
    .byte_in     (in_byte),
    .at_count    (at_count),
    .start_frame (start_frame),
    .zero_count  (zero_count),
    .add_payload (add_payload),
    .last_byte   (last_byte)
  );

  sum_acc #(.W(W)) u_sum (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (start_frame),
    .add_en  (add_payload),
    .byte_in (in_byte),
    .sum     (sum)
  );

  verdict_reg #(.W(W)) u_verdict (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .finish     (last_byte),
    .reject     (zero_count),
    .sum        (sum),
    .check_byte (in_byte),
    .done       (done),
    .result     (result)
  );
endmodule

// File: rtl/frame_sum_check_props.sv
module frame_sum_check_props #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] in_byte,
  input logic         in_valid,
  input logic         in_ready,
  input logic         done,
  input logic [W-1:0] result,
  input logic         at_count
);
  // R11: ready never falls once raised
  a_r11_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_ready) |-> in_ready);

  // R6: a pulse only follows a taken byte
  a_r6_done_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_ready));

  // R7: verdict holds outside pulses
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R4: verdict is one of the two codes
  a_r4_verdict_code: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result == '0 || result == '1));

  // R5: zero count refused on the next cycle
  a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && at_count && in_byte == '0) |=> (done && result == '1));

  // R9: after a verdict the sequencer waits for a count
  a_r9_back_to_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> at_count);
endmodule

bind frame_sum_check frame_sum_check_props #(.W(W)) u_props (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .in_byte  (in_byte),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .result   (result),
  .at_count (at_count)
);

// File: tb/frame_sum_check_test.sv
module frame_sum_check_test;
  localparam int NF = 8;
  localparam int MB = 8;

  // each row: count byte then the bytes that follow it
  localparam logic [7:0] VEC [NF][MB] = '{
    '{8'h04, 8'h10, 8'h20, 8'h30, 8'h60, 8'h00, 8'h00, 8'h00},
    '{8'h04, 8'h10, 8'h20, 8'h30, 8'h61, 8'h00, 8'h00, 8'h00},
    '{8'h03, 8'hF0, 8'h20, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h01, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h02, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h05, 8'h80, 8'h80, 8'h01, 8'h02, 8'h03, 8'h00, 8'h00},
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
  };
  localparam int         NB  [NF] = '{5, 5, 4, 2, 2, 3, 6, 1};
  localparam logic [7:0] EXP [NF] = '{8'h00, 8'hFF, 8'h00, 8'h00,
                                      8'hFF, 8'h00, 8'h00, 8'hFF};

  logic       clk;
  logic       rst_n;
  logic [7:0] in_byte;
  logic       in_valid;
  logic       in_ready;
  logic       done;
  logic [7:0] result;

  int total;
  int bad;
  int cycles;

  frame_sum_check uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_byte  (in_byte),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .done     (done),
    .result   (result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // called at a negedge; returns at the negedge after the taking edge
  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // one idle cycle with garbage on the data input
  task automatic idle_garbage(input logic [7:0] prev_res);
    in_valid = 1'b0;
    in_byte  = 8'hAA;
    @(posedge clk);
    @(negedge clk);
    check("R8 idle no pulse", {1'b0, done}, 9'd0);
    check("R7 result held", {1'b0, result}, {1'b0, prev_res});
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0] last_res;
    total    = 0;
    bad      = 0;
    in_valid = 1'b0;
    in_byte  = 8'h00;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset done", {1'b0, done}, 9'd0);
    check("R1 reset result", {1'b0, result}, 9'h000);
    check("R1 reset ready", {1'b0, in_ready}, 9'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ready after release", {1'b0, in_ready}, 9'd1);
    last_res = 8'h00;

    // table walk: even rows back to back (R9), odd rows with gaps (R8)
    for (int f = 0; f < NF; f++) begin
      for (int i = 0; i < NB[f]; i++) begin
        if (f % 2 == 1) idle_garbage(last_res);
        send(VEC[f][i]);
        if (i == NB[f] - 1) begin
          check("R2 R3 R4 R5 R10 verdict pulse", {1'b0, done}, 9'd1);
          check("R3 R4 R5 R10 verdict value", {1'b0, result}, {1'b0, EXP[f]});
          last_res = EXP[f];
        end else begin
          check("R6 no pulse mid frame", {1'b0, done}, 9'd0);
          check("R7 result held mid frame", {1'b0, result}, {1'b0, last_res});
        end
        check("R11 ready stays", {1'b0, in_ready}, 9'd1);
      end
    end

    // R6: pulse lasts one cycle
    @(posedge clk);
    @(negedge clk);
    check("R6 pulse one cycle", {1'b0, done}, 9'd0);
    check("R7 result held after pulse", {1'b0, result}, 9'h0FF);

    // R9: zero count directly followed by a good frame
    send(8'h00);
    check("R5 zero count pulse", {1'b0, done}, 9'd1);
    send(8'h02);
    check("R6 pulse dropped", {1'b0, done}, 9'd0);
    check("R7 FF held", {1'b0, result}, 9'h0FF);
    send(8'h7E);
    send(8'h7E);
    check("R9 R3 frame after zero count", {1'b0, result}, 9'h000);

    // R3: count byte excluded, and a sum that wraps
    send(8'h03);
    send(8'hFE);
    send(8'h03);
    send(8'h01);
    check("R3 wrap sum pass", {1'b0, result}, 9'h000);
    send(8'h03);
    send(8'h01);
    send(8'h01);
    send(8'h05);
    check("R3 count excluded", {1'b0, result}, 9'h0FF);

    finish_run();
  end
endmodule